// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This block sits in front of the arithmetic core of a double-precision fused multiply-add unit computing `addend + x * y`. It receives, for each of the three operands, a class code produced by an upstream classifier together with the raw 64-bit encoding. It also receives two sign-negation controls, one for the product and one for the addend, and the active rounding mode. From these it decides whether the result is fixed by the special-value rules or whether the arithmetic core must compute it.

When a special case applies, the block supplies the complete 64-bit result on a bypass path and raises the invalid-operation flag where required. Otherwise it asserts the compute request and leaves the bypass path at zero. All outputs are registered, so they appear one clock after the operands. The NaN rules follow a fixed operand priority. The infinity and zero rules use the effective signs of the product and the addend. When two zeros of opposite effective sign cancel, the rounding mode picks the sign of the zero.

Top module: `fmaspec_resolver`

## Requirements
- R1: Class codes are 3 bits: 0 zero, 1 normal, 2 denormal, 3 infinity, 4 quiet NaN, 5 signaling NaN. The effective product sign is bit 63 of x XOR bit 63 of y, inverted when `negProd` is 1. The effective addend sign is bit 63 of z, inverted when `negAdd` is 1.
- R2: When more than one operand is a NaN, the winner is chosen in this order: signaling z, signaling x, signaling y, quiet z, quiet x, quiet y.
- R3: A winning signaling NaN gives `invalidOp`=1 and a result equal to that operand's encoding with bit 51 set. Its sign and the rest of its payload are kept.
- R4: A winning quiet NaN is returned bit for bit unchanged, with `invalidOp`=0.
- R5: With no NaN present, infinity times zero in either order gives `invalidOp`=1 and the indefinite value `INDEF_NAN` (default 64'h7FF8_0000_0000_0000).
- R6: For an infinite product whose infinite addend has the opposite effective sign, the result is `invalidOp`=1 and `INDEF_NAN`. Any other infinite product gives infinity with the effective product sign: exponent all ones, fraction zero.
- R7: For a zero product: an infinite addend gives infinity with the effective addend sign. A non-zero finite addend gives z with its sign bit replaced by the effective addend sign.
- R8: For a zero product with a zero addend: when the effective signs match, the result is zero with that sign. When they differ, the result is +0, or -0 when `roundMode` equals `DOWN_MODE` (default 2'b11).
- R9: For a finite non-zero product with an infinite addend, the result is infinity with the effective addend sign and `invalidOp`=0.
- R10: For a finite non-zero product with a finite addend, `computeReq`=1 while `bypassValid`=0, `invalidOp`=0 and `bypassResult`=0. In every other case `bypassValid`=1 and `computeReq`=0.
- R11: Outputs are registered one clock after the inputs. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xClass | input | 3 | Class code of multiplicand x |
| yClass | input | 3 | Class code of multiplicand y |
| zClass | input | 3 | Class code of addend z |
| xRaw | input | 64 | Encoding of x |
| yRaw | input | 64 | Encoding of y |
| zRaw | input | 64 | Encoding of z |
| negProd | input | 1 | Invert the product sign |
| negAdd | input | 1 | Invert the addend sign |
| roundMode | input | 2 | Rounding mode |
| bypassValid | output | 1 | Result is supplied on the bypass path |
| bypassResult | output | 64 | Special-case result |
| invalidOp | output | 1 | Invalid-operation flag |
| computeReq | output | 1 | Arithmetic core must compute the result |

## Verification
On every cycle, the assertions check three things. The compute request and the bypass path never appear together. An invalid flag always comes with a NaN result. The signaling-z, x-over-z priority and infinity-times-zero outcomes appear in the cycle after their inputs. Sign handling needs full stimulus and can only be shown by the bench scenarios. This covers the negate controls, the cancellation of opposite zeros under each rounding mode, and infinity meeting infinity. Those scenarios also cover the tie-break among several NaNs of each kind, which they compare against a behavioural reference on each clock.

// File: rtl/fmaspec_pkg.sv
package fmaspec_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NORM = 3'd1,
    CLS_DNORM = 3'd2,
    CLS_INF = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } opClass_e;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_Z,
    SRC_X,
    SRC_Y,
    SRC_INDEF,
    SRC_INF,
    SRC_ZERO,
    SRC_ZSIGNED
  } resSrc_e;

  typedef struct packed {
    resSrc_e selSrc;
    logic    doQuiet;
    logic    signBit;
    logic    flagInvalid;
    logic    doCompute;
  } strobes_t;
endpackage

// File: rtl/fmaspec_ctrl.sv
module fmaspec_ctrl
  import fmaspec_pkg::*;
#(
  parameter logic [1:0] DOWN_MODE = 2'b11
) (
  input  opClass_e   xCls,
  input  opClass_e   yCls,
  input  opClass_e   zCls,
  input  logic       xSign,
  input  logic       ySign,
  input  logic       zSign,
  input  logic       negProd,
  input  logic       negAdd,
  input  logic [1:0] roundMode,
  output strobes_t   strobes
);
  logic prodSign, addSign;
  logic prodInf, prodZero, prodInvalid;

  // R1: effective signs
  assign prodSign = xSign ^ ySign ^ negProd;
  assign addSign = zSign ^ negAdd;

  assign prodInvalid = (xCls == CLS_INF && yCls == CLS_ZERO) ||
                       (xCls == CLS_ZERO && yCls == CLS_INF);
  assign prodInf = (xCls == CLS_INF) || (yCls == CLS_INF);
  assign prodZero = (xCls == CLS_ZERO) || (yCls == CLS_ZERO);

  always_comb begin
    strobes = '{selSrc: SRC_NONE, doQuiet: 1'b0, signBit: 1'b0,
                flagInvalid: 1'b0, doCompute: 1'b0};
    // R2: fixed NaN priority
    if (zCls == CLS_SNAN) begin
      strobes.selSrc = SRC_Z; strobes.doQuiet = 1'b1; strobes.flagInvalid = 1'b1;
    end else if (xCls == CLS_SNAN) begin
      strobes.selSrc = SRC_X; strobes.doQuiet = 1'b1; strobes.flagInvalid = 1'b1;
    end else if (yCls == CLS_SNAN) begin
      strobes.selSrc = SRC_Y; strobes.doQuiet = 1'b1; strobes.flagInvalid = 1'b1;
    end else if (zCls == CLS_QNAN) begin
      strobes.selSrc = SRC_Z;
    end else if (xCls == CLS_QNAN) begin
      strobes.selSrc = SRC_X;
    end else if (yCls == CLS_QNAN) begin
      strobes.selSrc = SRC_Y;
    end else if (prodInvalid) begin
      strobes.selSrc = SRC_INDEF; strobes.flagInvalid = 1'b1;
    end else if (prodInf) begin
      if (zCls == CLS_INF && addSign != prodSign) begin
        strobes.selSrc = SRC_INDEF; strobes.flagInvalid = 1'b1;
      end else begin
        strobes.selSrc = SRC_INF; strobes.signBit = prodSign;
      end
    end else if (zCls == CLS_INF) begin
      strobes.selSrc = SRC_INF; strobes.signBit = addSign;
    end else if (prodZero) begin
      if (zCls == CLS_ZERO && addSign != prodSign) begin
        strobes.selSrc = SRC_ZERO;
        strobes.signBit = (roundMode == DOWN_MODE);
      end else begin
        strobes.selSrc = SRC_ZSIGNED; strobes.signBit = addSign;
      end
    end else begin
      strobes.doCompute = 1'b1;
    end
  end
endmodule

// File: rtl/fmaspec_dp.sv
module fmaspec_dp
  import fmaspec_pkg::*;
#(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned EXPW = 11,
  parameter logic [WIDTH-1:0] INDEF_NAN = 64'h7FF8_0000_0000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobes_t         strobes,
  input  logic [WIDTH-1:0] xRaw,
  input  logic [WIDTH-1:0] yRaw,
  input  logic [WIDTH-1:0] zRaw,
  output logic             bypassValid,
  output logic [WIDTH-1:0] bypassResult,
  output logic             invalidOp,
  output logic             computeReq
);
  localparam int unsigned FRACW = WIDTH - 1 - EXPW;
  localparam logic [WIDTH-1:0] QUIET_MASK = {{(WIDTH-FRACW){1'b0}}, 1'b1, {(FRACW-1){1'b0}}};

  logic [WIDTH-1:0] picked, nextRes;

  always_comb begin
    unique case (strobes.selSrc)
      SRC_Z:   picked = zRaw;
      SRC_X:   picked = xRaw;
      SRC_Y:   picked = yRaw;
      default: picked = '0;
    endcase
  end

  always_comb begin
    unique case (strobes.selSrc)
      SRC_Z, SRC_X, SRC_Y: nextRes = strobes.doQuiet ? (picked | QUIET_MASK) : picked;
      SRC_INDEF:   nextRes = INDEF_NAN;
      SRC_INF:     nextRes = {strobes.signBit, {EXPW{1'b1}}, {FRACW{1'b0}}};
      SRC_ZERO:    nextRes = {strobes.signBit, {(WIDTH-1){1'b0}}};
      SRC_ZSIGNED: nextRes = {strobes.signBit, zRaw[WIDTH-2:0]};
      default:     nextRes = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bypassValid <= 1'b0;
      bypassResult <= '0;
      invalidOp <= 1'b0;
      computeReq <= 1'b0;
    end else begin
      bypassValid <= (strobes.selSrc != SRC_NONE);
      bypassResult <= nextRes;
      invalidOp <= strobes.flagInvalid;
      computeReq <= strobes.doCompute;
    end
  end

  assert_compute_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    computeReq |-> (!bypassValid && !invalidOp && bypassResult == '0));

  assert_invalid_is_nan_R3: assert property (@(posedge clk) disable iff (!rst_n)
    invalidOp |-> (bypassValid && (&bypassResult[WIDTH-2:FRACW]) && bypassResult[FRACW-1]));
endmodule

// File: rtl/fmaspec_resolver.sv
module fmaspec_resolver
  import fmaspec_pkg::*;
#(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned EXPW = 11,
  parameter logic [WIDTH-1:0] INDEF_NAN = 64'h7FF8_0000_0000_0000,
  parameter logic [1:0] DOWN_MODE = 2'b11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       xClass,
  input  logic [2:0]       yClass,
  input  logic [2:0]       zClass,
  input  logic [WIDTH-1:0] xRaw,
  input  logic [WIDTH-1:0] yRaw,
  input  logic [WIDTH-1:0] zRaw,
  input  logic             negProd,
  input  logic             negAdd,
  input  logic [1:0]       roundMode,
  output logic             bypassValid,
  output logic [WIDTH-1:0] bypassResult,
  output logic             invalidOp,
  output logic             computeReq
);
  localparam int unsigned FRACW = WIDTH - 1 - EXPW;
  localparam logic [WIDTH-1:0] QBIT = {{(WIDTH-FRACW){1'b0}}, 1'b1, {(FRACW-1){1'b0}}};

  strobes_t strobes;

  fmaspec_ctrl #(.DOWN_MODE(DOWN_MODE)) u_ctrl (
    .xCls(opClass_e'(xClass)), .yCls(opClass_e'(yClass)), .zCls(opClass_e'(zClass)),
    .xSign(xRaw[WIDTH-1]), .ySign(yRaw[WIDTH-1]), .zSign(zRaw[WIDTH-1]),
    .negProd(negProd), .negAdd(negAdd), .roundMode(roundMode), .strobes(strobes)
  );

  fmaspec_dp #(.WIDTH(WIDTH), .EXPW(EXPW), .INDEF_NAN(INDEF_NAN)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .xRaw(xRaw), .yRaw(yRaw), .zRaw(zRaw),
    .bypassValid(bypassValid), .bypassResult(bypassResult),
    .invalidOp(invalidOp), .computeReq(computeReq)
  );

  assert_snan_z_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (zClass == 3'd5) |=> (invalidOp && bypassResult == ($past(zRaw) | QBIT)));

  assert_x_snan_over_z_qnan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xClass == 3'd5 && zClass == 3'd4) |=> (bypassResult == ($past(xRaw) | QBIT)));

  assert_inf_times_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((zClass < 3'd4) && ((xClass == 3'd3 && yClass == 3'd0) || (xClass == 3'd0 && yClass == 3'd3)))
    |=> (invalidOp && bypassResult == INDEF_NAN));
endmodule

// File: tb/sim_fmaspec_resolver.sv
`timescale 1ns/1ps
module sim_fmaspec_resolver;
  localparam logic [63:0] INDEF = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] QB = 64'h0008_0000_0000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] xc = 0, yc = 0, zc = 0;
  logic [63:0] xr = 0, yr = 0, zr = 0;
  logic np = 0, na = 0;
  logic [1:0] rm = 0;
  logic bv, iv, cr;
  logic [63:0] res;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fmaspec_resolver u0 (
    .clk(clk), .rst_n(rst_n), .xClass(xc), .yClass(yc), .zClass(zc),
    .xRaw(xr), .yRaw(yr), .zRaw(zr), .negProd(np), .negAdd(na), .roundMode(rm),
    .bypassValid(bv), .bypassResult(res), .invalidOp(iv), .computeReq(cr)
  );

  function automatic logic [63:0] mk(input int cls, input logic s);
    logic [51:0] f;
    f = {$urandom(), $urandom()};
    case (cls)
      0: mk = {s, 63'd0};
      1: mk = {s, 11'($urandom_range(1, 2046)), f};
      2: mk = {s, 11'd0, f[51:1], 1'b1};
      3: mk = {s, 11'h7FF, 52'd0};
      4: mk = {s, 11'h7FF, 1'b1, f[50:0]};
      default: mk = {s, 11'h7FF, 1'b0, f[50:1], 1'b1};
    endcase
  endfunction

  // Behavioural reference
  task automatic refModel(output logic ebv, output logic [63:0] eres,
                          output logic eiv, output logic ecr, output string tag);
    logic ps, zs;
    int nanCount;
    ps = xr[63] ^ yr[63] ^ np;
    zs = zr[63] ^ na;
    ebv = 1; eres = 0; eiv = 0; ecr = 0;
    nanCount = int'(xc >= 4) + int'(yc >= 4) + int'(zc >= 4);
    if (zc == 5)      begin eres = zr | QB; eiv = 1; tag = "R3"; end
    else if (xc == 5) begin eres = xr | QB; eiv = 1; tag = "R3"; end
    else if (yc == 5) begin eres = yr | QB; eiv = 1; tag = "R3"; end
    else if (zc == 4) begin eres = zr; tag = "R4"; end
    else if (xc == 4) begin eres = xr; tag = "R4"; end
    else if (yc == 4) begin eres = yr; tag = "R4"; end
    else if ((xc == 3 && yc == 0) || (xc == 0 && yc == 3)) begin
      eres = INDEF; eiv = 1; tag = "R5";
    end else if (xc == 3 || yc == 3) begin
      tag = "R6";
      if (zc == 3 && zs != ps) begin eres = INDEF; eiv = 1; end
      else eres = {ps, 11'h7FF, 52'd0};
    end else if (xc == 0 || yc == 0) begin
      if (zc == 3) begin eres = {zs, 11'h7FF, 52'd0}; tag = "R7"; end
      else if (zc == 0) begin
        tag = "R8";
        eres = (zs == ps) ? {zs, 63'd0} : {rm == 2'b11, 63'd0};
      end else begin eres = {zs, zr[62:0]}; tag = "R7"; end
    end else if (zc == 3) begin
      eres = {zs, 11'h7FF, 52'd0}; tag = "R9";
    end else begin
      ebv = 0; ecr = 1; tag = "R10";
    end
    if (nanCount > 1) tag = {"R2/", tag};
  endtask

  task automatic apply(input int cx, input int cy, input int cz,
                       input logic sx, input logic sy, input logic sz,
                       input logic p, input logic a, input logic [1:0] r,
                       input string label);
    logic ebv, eiv, ecr;
    logic [63:0] eres;
    string tag;
    @(negedge clk);
    xc = 3'(cx); yc = 3'(cy); zc = 3'(cz);
    xr = mk(cx, sx); yr = mk(cy, sy); zr = mk(cz, sz);
    np = p; na = a; rm = r;
    refModel(ebv, eres, eiv, ecr, tag);
    @(posedge clk);
    #1;
    checks++;
    if (bv !== ebv || res !== eres || iv !== eiv || cr !== ecr) begin
      failures++;
      $display("FAIL %s R1 %s: got bv=%b res=%h iv=%b cr=%b exp bv=%b res=%h iv=%b cr=%b",
               tag, label, bv, res, iv, cr, ebv, eres, eiv, ecr);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (bv !== 0 || res !== 0 || iv !== 0 || cr !== 0) begin
      failures++;
      $display("FAIL R11 reset: got bv=%b res=%h iv=%b cr=%b exp all zero", bv, res, iv, cr);
    end
    @(negedge clk) rst_n = 1'b1;
    // R2 priority scenarios
    apply(5, 5, 5, 0, 1, 1, 0, 0, 0, "R2 snan z wins");
    apply(5, 5, 4, 1, 0, 0, 0, 0, 0, "R2 snan x over qnan z");
    apply(4, 5, 4, 0, 0, 1, 0, 0, 0, "R2 snan y over qnans");
    apply(4, 4, 1, 1, 0, 0, 0, 0, 0, "R2 qnan x over y");
    apply(1, 4, 3, 0, 1, 0, 1, 1, 0, "R4 qnan y");
    // R5
    apply(3, 0, 1, 0, 0, 0, 0, 0, 0, "R5 inf*0");
    apply(0, 3, 3, 1, 0, 0, 0, 0, 0, "R5 0*inf");
    // R6 with negate controls (R1)
    apply(3, 1, 3, 0, 0, 1, 0, 0, 0, "R6 opposite infs");
    apply(3, 1, 3, 0, 0, 1, 0, 1, 0, "R6 negAdd aligns");
    apply(2, 3, 3, 1, 0, 1, 1, 0, 0, "R6 negProd opposes");
    apply(3, 3, 1, 1, 0, 0, 1, 0, 0, "R6 inf product sign");
    // R7, R8
    apply(0, 1, 3, 0, 0, 1, 0, 1, 0, "R7 zero prod inf z");
    apply(2, 0, 1, 0, 0, 1, 0, 1, 0, "R7 zero prod finite z negAdd");
    apply(0, 0, 0, 1, 0, 1, 0, 0, 0, "R8 same sign zeros");
    apply(0, 0, 0, 0, 0, 1, 0, 0, 2'b00, "R8 opposite zeros nearest");
    apply(0, 0, 0, 0, 0, 1, 0, 0, 2'b11, "R8 opposite zeros down");
    apply(0, 1, 0, 0, 0, 0, 1, 0, 2'b11, "R8 negProd opposite down");
    // R9, R10
    apply(1, 2, 3, 0, 1, 1, 0, 0, 0, "R9 finite prod inf z");
    apply(1, 1, 1, 0, 0, 0, 0, 0, 0, "R10 compute");
    apply(2, 2, 0, 1, 1, 0, 1, 1, 1, "R10 compute zero z");
    // random sweep
    for (int i = 0; i < 600; i++)
      apply($urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(0, 5),
            1'($urandom()), 1'($urandom()), 1'($urandom()),
            1'($urandom()), 1'($urandom()), 2'($urandom()), "random");
    // R11 reset again
    @(negedge clk) rst_n = 1'b0;
    #1;
    checks++;
    if (bv !== 0 || res !== 0 || iv !== 0 || cr !== 0) begin
      failures++;
      $display("FAIL R11 mid reset: got bv=%b res=%h iv=%b cr=%b exp all zero", bv, res, iv, cr);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule